// File: doc/BRIEF.md
# Non-preemptive DMA stream bus arbiter

This block decides which of several DMA stream channels may drive a single 32-bit system bus master port. Each stream presents a request, a priority and a burst-length code. When the bus is free, the arbiter picks one requester, latches its burst length and grants it the bus. The granted stream then keeps the grant for the whole transaction. A transaction is either a single beat or a programmed burst of beats, and each beat is accepted through a valid/ready handshake on the bus side.

After the last beat is accepted, the arbiter inserts exactly one arbitration cycle. During that cycle no stream is granted but the bus is still marked busy. The next winner, if there is one, is granted at the end of that cycle. Address generation, data movement and the bus protocol itself belong to the surrounding DMA engine. The arbiter only sequences ownership and counts beats.

Top module: `stream_bus_arbiter`

## Requirements
- R1: While reset is asserted, grant, bus_busy, beat_valid and txn_done are all low, whatever the requests.
- R2: Grant is never held by more than one stream. When no stream requests and the bus is idle, every grant line stays low.
- R3: A request seen on a clock edge while the bus is idle produces a grant and bus_busy high from that edge onward.
- R4: Among simultaneous requesters, the stream with the numerically largest priority value wins. Priority is 2 bits per stream, with stream i at bits [2i+1:2i].
- R5: Requesters with equal priority are resolved in favour of the lowest stream index.
- R6: The burst code (2 bits per stream, stream i at bits [2i+1:2i]) selects the transaction length: 00 gives 1 beat, 01 gives 4, 10 gives 8 and 11 gives 16 accepted beats.
- R7: Once granted, a stream keeps the grant until its last beat is accepted. Dropping its request or a higher-priority request arriving does not remove the grant.
- R8: beat_valid is high for every cycle of the grant. A beat counts only in a cycle where bus_ready is also high, so stalls lengthen the transaction.
- R9: txn_done is high for exactly one cycle, in the cycle where the final beat is accepted.
- R10: The cycle after txn_done has no grant and bus_busy high. A stream requesting then is granted at the following edge; otherwise the bus goes idle.
- R11: Changes to priority or burst inputs while a transaction runs do not alter its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_req | input | N_STREAMS | Per-stream transfer request |
| stream_prio | input | N_STREAMS*PRIO_W | Per-stream priority, larger wins |
| stream_burst | input | N_STREAMS*2 | Per-stream burst-length code |
| bus_ready | input | 1 | Bus accepts the current beat |
| grant | output | N_STREAMS | One-hot stream ownership |
| bus_busy | output | 1 | Bus held, including the arbitration cycle |
| beat_valid | output | 1 | A beat is being offered to the bus |
| txn_done | output | 1 | Final beat of the transaction accepted |

## Verification
A wrong beat count appears at the ports as txn_done arriving early or late. It is caught on the cycle the final beat should have been accepted, and in every case before the next grant. A corrupted state register shows up within one cycle. It appears as grant and beat_valid disagreeing, as a grant changing in mid-burst, or as a missing idle gap after txn_done. Arbitration errors appear on the first cycle of the grant, because the owner is compared against an expected winner worked out from the priorities and indices.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } sba_state_e;

  localparam int unsigned BURST_CODE_W = 2;
  localparam int unsigned MAX_BEATS    = 16;
  localparam int unsigned BEAT_CNT_W   = $clog2(MAX_BEATS + 1);

  function automatic logic [BEAT_CNT_W-1:0] beats_of(input logic [BURST_CODE_W-1:0] code);
    logic [BEAT_CNT_W-1:0] n;
    case (code)
      2'b00:   n = BEAT_CNT_W'(1);
      2'b01:   n = BEAT_CNT_W'(4);
      2'b10:   n = BEAT_CNT_W'(8);
      default: n = BEAT_CNT_W'(16);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sba_pick.sv
module sba_pick #(
  parameter int unsigned N_STREAMS = 4,
  parameter int unsigned PRIO_W    = 2,
  localparam int unsigned IDX_W    = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic [N_STREAMS-1:0]        req,
  input  logic [N_STREAMS*PRIO_W-1:0] prio,
  output logic [N_STREAMS-1:0]        win_oh,
  output logic [IDX_W-1:0]            win_idx,
  output logic                        any
);

  logic [PRIO_W-1:0] best_prio;

  // Strictly-greater compare keeps the earliest index on a tie.
  always_comb begin
    any       = 1'b0;
    win_idx   = '0;
    best_prio = '0;
    for (int i = 0; i < N_STREAMS; i++) begin
      if (req[i] && (!any || (prio[i*PRIO_W +: PRIO_W] > best_prio))) begin
        any       = 1'b1;
        win_idx   = IDX_W'(i);
        best_prio = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  generate
    for (genvar g = 0; g < N_STREAMS; g++) begin : g_oh
      assign win_oh[g] = any && (win_idx == IDX_W'(g));
    end
  endgenerate

endmodule

// File: rtl/sba_beat_cnt.sv
module sba_beat_cnt #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [CNT_W-1:0] len,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || dec;
    cnt_d  = load ? len : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/stream_bus_arbiter.sv
module stream_bus_arbiter
  import sba_pkg::*;
#(
  parameter int unsigned N_STREAMS = 4,
  parameter int unsigned PRIO_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_STREAMS-1:0]        stream_req,
  input  logic [N_STREAMS*PRIO_W-1:0] stream_prio,
  input  logic [N_STREAMS*2-1:0]      stream_burst,
  input  logic                        bus_ready,
  output logic [N_STREAMS-1:0]        grant,
  output logic                        bus_busy,
  output logic                        beat_valid,
  output logic                        txn_done
);

  localparam int unsigned IDX_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1;

  sba_state_e             state_q, state_d;
  logic [N_STREAMS-1:0]   grant_q, grant_d;
  logic                   grant_en;
  logic [N_STREAMS-1:0]   win_oh;
  logic [IDX_W-1:0]       win_idx;
  logic                   win_any;
  logic                   can_arb, start, accept, cnt_last, last_beat;
  logic [BURST_CODE_W-1:0] win_code;

  sba_pick #(
    .N_STREAMS(N_STREAMS),
    .PRIO_W   (PRIO_W)
  ) u_pick (
    .req    (stream_req),
    .prio   (stream_prio),
    .win_oh (win_oh),
    .win_idx(win_idx),
    .any    (win_any)
  );

  assign win_code = stream_burst[win_idx*BURST_CODE_W +: BURST_CODE_W];

  sba_beat_cnt #(
    .CNT_W(BEAT_CNT_W)
  ) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .load (start),
    .dec  (accept),
    .len  (beats_of(win_code)),
    .last (cnt_last)
  );

  always_comb begin
    can_arb   = (state_q != ST_XFER);
    start     = can_arb && win_any;
    accept    = (state_q == ST_XFER) && bus_ready;
    last_beat = accept && cnt_last;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start)     state_d = ST_XFER;
      ST_XFER: if (last_beat) state_d = ST_GAP;
      ST_GAP:  state_d = start ? ST_XFER : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    grant_en = start || last_beat;
    grant_d  = start ? win_oh : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        grant_q <= '0;
    else if (grant_en) grant_q <= grant_d;
  end

  assign grant      = grant_q;
  assign bus_busy   = (state_q != ST_IDLE);
  assign beat_valid = (state_q == ST_XFER);
  assign txn_done   = last_beat;

endmodule

// File: rtl/sba_chk.sv
module sba_chk #(
  parameter int unsigned N_STREAMS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_ready,
  input logic [N_STREAMS-1:0] grant,
  input logic                 bus_busy,
  input logic                 beat_valid,
  input logic                 txn_done
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R8
  valid_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (grant != '0));

  // R8
  grant_drives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> beat_valid);

  // R9
  done_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |-> (beat_valid && bus_ready));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> !txn_done);

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !txn_done) |=> (grant == $past(grant)));

  // R10
  gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_done |=> ((grant == '0) && bus_busy));

  // R3
  busy_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> bus_busy);

endmodule

bind stream_bus_arbiter sba_chk #(
  .N_STREAMS(N_STREAMS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_ready (bus_ready),
  .grant     (grant),
  .bus_busy  (bus_busy),
  .beat_valid(beat_valid),
  .txn_done  (txn_done)
);

// File: tb/sim_stream_bus_arbiter.sv
module sim_stream_bus_arbiter;

  logic       clk;
  logic       rst_n;
  logic [3:0] req;
  logic [7:0] prio;
  logic [7:0] burst;
  logic       bus_ready;
  logic [3:0] grant;
  logic       bus_busy;
  logic       beat_valid;
  logic       txn_done;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  stream_bus_arbiter #(.N_STREAMS(4), .PRIO_W(2)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .stream_req  (req),
    .stream_prio (prio),
    .stream_burst(burst),
    .bus_ready   (bus_ready),
    .grant       (grant),
    .bus_busy    (bus_busy),
    .beat_valid  (beat_valid),
    .txn_done    (txn_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req, prio, burst, expected grant, expected beats}
  localparam int NV = 6;
  localparam logic [28:0] VEC [NV] = '{
    {4'b0001, 8'b00000000, 8'b00000000, 4'b0001, 5'd1},   // R3 R6 single
    {4'b0110, 8'b00110100, 8'b00010000, 4'b0100, 5'd4},   // R4 R6
    {4'b1111, 8'b10101010, 8'b00000010, 4'b0001, 5'd8},   // R5 R6
    {4'b1010, 8'b11001100, 8'b00001100, 4'b0010, 5'd16},  // R5 R6
    {4'b1000, 8'b00000000, 8'b11000000, 4'b1000, 5'd16},  // R6
    {4'b1100, 8'b01000000, 8'b00000000, 4'b1000, 5'd1}    // R4
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_txn(input logic [3:0] r, input logic [7:0] p, input logic [7:0] b,
                         input logic [3:0] eg, input int eb, input string tag);
    int beats;
    int guard;
    bit bad_grant;
    @(negedge clk);
    req = r; prio = p; burst = b; bus_ready = 1'b1;
    @(negedge clk);
    chk({tag, " grant"}, grant, eg);
    chk("R3 busy on grant", bus_busy, 1);
    req = '0;
    beats = 0; guard = 0; bad_grant = 0;
    forever begin
      #1;
      if (beat_valid && bus_ready) beats++;
      if (grant != eg) bad_grant = 1;
      if (txn_done || guard > 40) break;
      guard++;
      @(negedge clk);
    end
    chk("R7 grant held", bad_grant, 0);
    chk({tag, " R6 beats"}, beats, eb);
    @(negedge clk);
    chk("R10 gap grant low", grant, 0);
    chk("R10 gap busy", bus_busy, 1);
    @(negedge clk);
    chk("R10 idle after gap", bus_busy, 0);
    chk("R2 idle grant low", grant, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_errs++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    int beats;
    int done_cyc;
    bit bad;
    rst_n = 1'b0; req = 4'b1111; prio = 8'hFF; burst = 8'hFF; bus_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", grant, 0);
    chk("R1 busy in reset", bus_busy, 0);
    chk("R1 valid in reset", beat_valid, 0);
    chk("R1 done in reset", txn_done, 0);
    req = '0;
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 no request no grant", grant, 0);
    chk("R2 no request idle", bus_busy, 0);

    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i][28:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:5],
              int'(VEC[i][4:0]), "R4/R5 vector");
    end

    // R7 R11 R10: higher-priority arrival and input changes mid-burst
    @(negedge clk);
    req = 4'b0001; prio = 8'b00000000; burst = 8'b00000001; bus_ready = 1'b1;
    @(negedge clk);
    chk("R7 first owner", grant, 4'b0001);
    req = 4'b1000; prio = 8'b11000000; burst = 8'b11000011;
    beats = 0; bad = 0;
    for (int c = 0; c < 40; c++) begin
      #1;
      if (beat_valid && bus_ready) beats++;
      if (grant != 4'b0001) bad = 1;
      if (txn_done) break;
      @(negedge clk);
    end
    chk("R7 no preemption", bad, 0);
    chk("R11 length latched", beats, 4);
    @(negedge clk);
    chk("R10 gap with pending req", grant, 0);
    chk("R10 gap busy pending", bus_busy, 1);
    @(negedge clk);
    chk("R10 next owner after gap", grant, 4'b1000);
    req = '0;
    beats = 0;
    for (int c = 0; c < 40; c++) begin
      #1;
      if (beat_valid && bus_ready) beats++;
      if (txn_done) break;
      @(negedge clk);
    end
    chk("R6 sixteen beats", beats, 16);
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle after second", bus_busy, 0);

    // R8 R9: stalls with bus_ready low two of every three cycles
    @(negedge clk);
    req = 4'b0010; prio = 8'b00000000; burst = 8'b00000100; bus_ready = 1'b0;
    @(negedge clk);
    chk("R8 stall owner", grant, 4'b0010);
    req = '0;
    beats = 0; bad = 0; done_cyc = -1;
    for (int c = 0; c < 40; c++) begin
      bus_ready = (c % 3 == 2);
      #1;
      if (!beat_valid) bad = 1;
      if (beat_valid && bus_ready) beats++;
      if (txn_done) begin done_cyc = c; break; end
      @(negedge clk);
    end
    chk("R8 valid held through stall", bad, 0);
    chk("R8 beats with stalls", beats, 4);
    chk("R9 done on last accept", done_cyc, 11);
    @(negedge clk);
    bus_ready = 1'b1;
    #1;
    chk("R9 done one cycle", txn_done, 0);
    chk("R10 gap after stall", bus_busy, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule